// File: doc/BRIEF.md
# Extended Indexed Operand Address Generator

This block sits beside the instruction fetch path of a 16-bit processor whose instructions can be prefixed by an extension word. It consumes the fetched word stream one word at a time: first the extension word, then the opcode word, then zero, one or two index words. For each indexed operand it joins a 4-bit upper index field taken from the extension word with the 16-bit index word to form a 20-bit index. It then adds that index to the 20-bit content of the operand's base register.

The decode stage tells the block, alongside the opcode word, whether the source operand, the destination operand, or both use indexed addressing. The base register values are read-only inputs and the block never writes them back. Each finished address is presented with a one-cycle valid pulse. When the last word of an instruction has been taken, the block also pulses a completion strobe with the instruction's length in words.

Top module: `xidx_addr_gen`

## Requirements
- R1: Each effective address equals the 20-bit base plus the 20-bit index, reduced modulo 2^20; a carry out of bit 19 is lost.
- R2: The upper four bits of the source index are extension word bits [10:7]. The upper four bits of the destination index are extension word bits [3:0]. All other extension word bits have no effect on either address.
- R3: When both operands are indexed, the first index word after the opcode word belongs to the source and the second to the destination.
- R4: `src_addr_valid` and `dst_addr_valid` each go high for exactly one cycle. That cycle is the one right after the matching index word is accepted.
- R5: `instr_done` pulses for one cycle, in the cycle after the last word of the instruction is accepted. `instr_words` then holds the word count as an unsigned number: 2 with no indexed operand, 3 with one, 4 with two.
- R6: `src_is_idx` and `dst_is_idx` are sampled only when the opcode word (the second word of an instruction) is accepted. Their value at any other word has no effect.
- R7: The base value used is the one on `src_base` or `dst_base` in the cycle that the matching index word is accepted. Values present at other times have no effect.
- R8: A word is accepted only on a rising edge where both `word_valid` and `word_ready` are high. While `word_valid` is low the block makes no progress and raises no strobe.
- R9: While `rst` is high on a rising edge, the block drops any partly collected instruction, clears all strobes and holds `word_ready` low. The next accepted word is treated as an extension word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Instruction word offered |
| word_ready | output | 1 | Block can take a word |
| word_data | input | 16 | Instruction word |
| src_is_idx | input | 1 | Source uses indexed mode (taken with the opcode word) |
| dst_is_idx | input | 1 | Destination uses indexed mode (taken with the opcode word) |
| src_base | input | 20 | Source base register content |
| dst_base | input | 20 | Destination base register content |
| src_addr | output | 20 | Source effective address |
| src_addr_valid | output | 1 | One-cycle strobe for `src_addr` |
| dst_addr | output | 20 | Destination effective address |
| dst_addr_valid | output | 1 | One-cycle strobe for `dst_addr` |
| instr_words | output | 3 | Length of the finished instruction in words |
| instr_done | output | 1 | One-cycle strobe for `instr_words` |

## Verification
Every result is registered once. An address, and the length of an instruction, therefore appear in the first cycle after the rising edge that takes the word completing them. The bench drives each word on a falling edge and lets one rising edge take it. On the next falling edge it records the outputs caused by that word. It also records strobes on every idle falling edge, so a pulse that arrives early, arrives late, or lasts two cycles shows up as a wrong strobe count.

// File: rtl/xidx_addr_gen.sv
module xidx_addr_gen #(
  parameter int ADDR_W  = 20,
  parameter int WORD_W  = 16,
  parameter int SRC_LSB = 7,
  parameter int DST_LSB = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  input  logic              src_is_idx,
  input  logic              dst_is_idx,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  output logic [ADDR_W-1:0] src_addr,
  output logic              src_addr_valid,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dst_addr_valid,
  output logic [2:0]        instr_words,
  output logic              instr_done
);
  localparam int HI_W = ADDR_W - WORD_W;

  typedef enum logic [1:0] {ST_EXT, ST_OP, ST_SRC, ST_DST} st_t;

  st_t             st;
  logic [HI_W-1:0] src_hi, dst_hi;
  logic            dst_pend, src_used;

  wire take = word_valid & word_ready;
  assign word_ready = ~rst;

  wire [ADDR_W-1:0] src_idx = {src_hi, word_data};
  wire [ADDR_W-1:0] dst_idx = {dst_hi, word_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_EXT;
      src_hi         <= '0;
      dst_hi         <= '0;
      dst_pend       <= 1'b0;
      src_used       <= 1'b0;
      src_addr       <= '0;
      dst_addr       <= '0;
      src_addr_valid <= 1'b0;
      dst_addr_valid <= 1'b0;
      instr_words    <= '0;
      instr_done     <= 1'b0;
    end else begin
      src_addr_valid <= 1'b0;
      dst_addr_valid <= 1'b0;
      instr_done     <= 1'b0;
      if (take) begin
        unique case (st)
          ST_EXT: begin
            src_hi <= word_data[SRC_LSB +: HI_W];
            dst_hi <= word_data[DST_LSB +: HI_W];
            st     <= ST_OP;
          end
          ST_OP: begin
            dst_pend <= dst_is_idx;
            src_used <= src_is_idx;
            if (src_is_idx) st <= ST_SRC;
            else if (dst_is_idx) st <= ST_DST;
            else begin
              st          <= ST_EXT;
              instr_words <= 3'd2;
              instr_done  <= 1'b1;
            end
          end
          ST_SRC: begin
            src_addr       <= src_base + src_idx;
            src_addr_valid <= 1'b1;
            if (dst_pend) st <= ST_DST;
            else begin
              st          <= ST_EXT;
              instr_words <= 3'd3;
              instr_done  <= 1'b1;
            end
          end
          ST_DST: begin
            dst_addr       <= dst_base + dst_idx;
            dst_addr_valid <= 1'b1;
            st             <= ST_EXT;
            instr_words    <= src_used ? 3'd4 : 3'd3;
            instr_done     <= 1'b1;
          end
          default: st <= ST_EXT;
        endcase
      end
    end
  end

  p_src_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    src_addr_valid |=> !src_addr_valid);
  p_dst_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    dst_addr_valid |=> !dst_addr_valid);
  p_src_after_word_r8: assert property (@(posedge clk) disable iff (rst)
    src_addr_valid |-> $past(word_valid && word_ready));
  p_dst_after_word_r8: assert property (@(posedge clk) disable iff (rst)
    dst_addr_valid |-> $past(word_valid && word_ready));
  p_one_addr_per_word_r3: assert property (@(posedge clk) disable iff (rst)
    !(src_addr_valid && dst_addr_valid));
  p_len_legal_r5: assert property (@(posedge clk) disable iff (rst)
    instr_done |-> (instr_words >= 3'd2 && instr_words <= 3'd4));
  p_four_ends_dst_r5: assert property (@(posedge clk) disable iff (rst)
    (instr_done && instr_words == 3'd4) |-> dst_addr_valid);
  p_addr_has_done_r5: assert property (@(posedge clk) disable iff (rst)
    dst_addr_valid |-> instr_done);
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!src_addr_valid && !dst_addr_valid && !instr_done));
endmodule

// File: tb/xidx_addr_gen_test.sv
module xidx_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [15:0] word_data = '0;
  logic        src_is_idx = 1'b0, dst_is_idx = 1'b0;
  logic [19:0] src_base = '0, dst_base = '0;
  logic [19:0] src_addr, dst_addr;
  logic        src_addr_valid, dst_addr_valid, instr_done;
  logic [2:0]  instr_words;

  int n_run = 0, n_fail = 0;
  int n_src, n_dst, n_done;
  logic [19:0] got_s, got_d;
  logic [2:0]  got_len;

  always #2 clk = ~clk;

  xidx_addr_gen uut (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .src_is_idx(src_is_idx), .dst_is_idx(dst_is_idx),
    .src_base(src_base), .dst_base(dst_base), .src_addr(src_addr),
    .src_addr_valid(src_addr_valid), .dst_addr(dst_addr),
    .dst_addr_valid(dst_addr_valid), .instr_words(instr_words),
    .instr_done(instr_done)
  );

  typedef struct packed {
    logic [15:0] ext;
    logic        sf;
    logic        df;
    logic [15:0] sidx;
    logic [15:0] didx;
    logic [19:0] sb;
    logic [19:0] db;
    logic [19:0] exp_s;
    logic [19:0] exp_d;
    logic [2:0]  exp_len;
    logic        gap;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'h0083, 1'b1, 1'b1, 16'h2346, 16'h2100, 20'h23456, 20'h45678, 20'h3579C, 20'h77778, 3'd4, 1'b0},
    '{16'h0500, 1'b1, 1'b0, 16'h1234, 16'h0000, 20'h01000, 20'h00000, 20'hA2234, 20'h00000, 3'd3, 1'b0},
    '{16'h000F, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 20'h00000, 20'h00002, 20'h00000, 20'h00001, 3'd3, 1'b0},
    '{16'h0787, 1'b0, 1'b0, 16'h0000, 16'h0000, 20'h00000, 20'h00000, 20'h00000, 20'h00000, 3'd2, 1'b1},
    '{16'hFC75, 1'b1, 1'b1, 16'h0001, 16'h0010, 20'h7FFFF, 20'h10000, 20'h00000, 20'h60010, 3'd4, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic capture();
    if (src_addr_valid) begin n_src++; got_s = src_addr; end
    if (dst_addr_valid) begin n_dst++; got_d = dst_addr; end
    if (instr_done) begin n_done++; got_len = instr_words; end
  endtask

  task automatic clear_counts();
    n_src = 0; n_dst = 0; n_done = 0; got_s = '0; got_d = '0; got_len = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      word_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      capture();
    end
  endtask

  task automatic send(input logic [15:0] d, input logic sf, input logic df,
                      input logic [19:0] sb, input logic [19:0] db);
    word_valid = 1'b1; word_data = d; src_is_idx = sf; dst_is_idx = df;
    src_base = sb; dst_base = db;
    @(posedge clk); @(negedge clk);
    word_valid = 1'b0; src_is_idx = 1'b1; dst_is_idx = 1'b1;
    src_base = 20'hDEAD5; dst_base = 20'hBEEF3;
    capture();
  endtask

  task automatic run_vec(input vec_t v, input int k);
    clear_counts();
    send(v.ext, 1'b1, 1'b1, 20'h13579, 20'h2468A);
    if (v.gap) idle(2);
    send({4'h0, 12'h123}, v.sf, v.df, 20'h11111, 20'h22222);
    if (v.gap) idle(1);
    if (v.sf) begin
      send(v.sidx, 1'b0, 1'b0, v.sb, 20'h33333);
      if (v.gap) idle(3);
    end
    if (v.df) send(v.didx, 1'b0, 1'b0, 20'h44444, v.db);
    idle(2);
    check(n_src == int'(v.sf), $sformatf("R4 vec%0d src strobe count", k), n_src, v.sf);
    check(n_dst == int'(v.df), $sformatf("R4 vec%0d dst strobe count", k), n_dst, v.df);
    if (v.sf) check(got_s == v.exp_s, $sformatf("R1 R2 R7 vec%0d src addr", k), got_s, v.exp_s);
    if (v.df) check(got_d == v.exp_d, $sformatf("R1 R2 R3 R7 vec%0d dst addr", k), got_d, v.exp_d);
    check(n_done == 1, $sformatf("R5 vec%0d done count", k), n_done, 1);
    check(got_len == v.exp_len, $sformatf("R5 R6 vec%0d length", k), got_len, v.exp_len);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(word_ready == 1'b0, "R9 ready low in reset", word_ready, 0);
        check(!src_addr_valid && !dst_addr_valid && !instr_done, "R9 strobes low in reset",
              {src_addr_valid, dst_addr_valid, instr_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(word_ready == 1'b1, "R8 ready high after reset", word_ready, 1);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        clear_counts();
        idle(6);
        check(n_src + n_dst + n_done == 0, "R8 no strobe while idle", n_src + n_dst + n_done, 0);

        clear_counts();
        send(16'h0080, 1'b1, 1'b1, 20'h0, 20'h0);
        send(16'h0000, 1'b1, 1'b0, 20'h0, 20'h0);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        capture();
        rst = 1'b0;
        check(n_src + n_dst + n_done == 0, "R9 no strobe after mid reset", n_src + n_dst + n_done, 0);
        run_vec(VECS[1], 10);

        clear_counts();
        send(16'h0000, 1'b0, 1'b0, 20'h0, 20'h0);
        send(16'h0000, 1'b0, 1'b1, 20'h0, 20'h0);
        check(n_done == 0, "R6 no done before dst index word", n_done, 0);
        send(16'h8000, 1'b1, 1'b0, 20'h0, 20'h7FFFF);
        idle(1);
        check(n_src == 0 && n_dst == 1, "R6 only dst indexed", {n_src[15:0], n_dst[15:0]}, 1);
        check(got_d == 20'h87FFF, "R1 dst with zero upper bits", got_d, 20'h87FFF);
        check(got_len == 3'd3, "R5 dst-only length", got_len, 3);
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule